// File: doc/BRIEF.md
# Cross-Rate Serial Pass-Through Channel

This block carries one channel of serial data between two serial ports that keep their own timing. Each port has its own bit clock and frame sync. Both bit clocks arrive as slow level signals that are synchronous to one fast system clock. The block finds their edges on that clock, so no second clock domain exists inside. On the receive side, an 8-bit word is shifted in MSB first, starting at the frame sync. The complete word is then placed into a single holding latch.

On the transmit side, the rising edge of the transmit frame sync loads a parallel-to-serial shifter. In through mode the shifter takes the latched 8-bit word. In coded mode it takes a 4-bit code from a parallel input. The word is driven MSB first while an output enable is high. The enable then drops, which releases the line: the enable models an open-drain pad, and enable low means high impedance.

The two ports have unrelated rates and frame phases. A receive word can therefore be lost because a newer one replaced it, or sent twice because no newer one arrived. A one-cycle slip pulse reports either case.

Top module: `xrate_thru`

## Requirements
- R1: After reset, tx_oe_o, tx_data_o and slip_o are all low.
- R2: A receive frame starts at the first rx bit clock falling edge where rx_sync_i is high after being seen low at the previous falling edge. The bit sampled there is the MSB. The next seven falling edges supply the remaining bits, and the eighth bit completes the word into the latch.
- R3: In through mode, a rising tx_sync_i loads the latched word. One system clock after the sync edge is seen, the MSB is driven with tx_oe_o high. Each tx bit clock rising edge moves to the next bit, and tx_oe_o falls at the 8th rising edge after the load.
- R4: In coded mode, the 4-bit code_i sampled at the load is driven MSB first, and tx_oe_o falls at the 4th rising edge.
- R5: thru_i matters only in the cycle the sync edge is seen. Changing it during a frame alters neither the data nor the frame length.
- R6: A word completed before the tx sync rises is sent in that frame. If the sync rises while a receive word is still arriving, the earlier word is sent, and the new word goes out in the following frame.
- R7: If a word is completed while the previous one has not yet been loaded, slip_o pulses for one cycle and the newer word replaces the older one.
- R8: A through-mode load with no new word since the last load (after at least one word has arrived) sends the old word again and pulses slip_o.
- R9: A coded-mode load does not consume the latch. A word latched before it is still sent by the next through-mode load, and no slip is reported.
- R10: When a word is completed in the same cycle as a through-mode load, the new word is sent. There is no slip if the latch held no unsent word.
- R11: While tx_oe_o is low, tx_data_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bclk_i | input | 1 | Receive bit clock level |
| rx_sync_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Receive serial data |
| tx_bclk_i | input | 1 | Transmit bit clock level |
| tx_sync_i | input | 1 | Transmit frame sync; rising edge loads the shifter |
| thru_i | input | 1 | 1 = through word, 0 = coded word |
| code_i | input | 4 | Parallel coded word for coded mode |
| tx_data_o | output | 1 | Transmit serial data |
| tx_oe_o | output | 1 | Transmit line enable; low means released |
| slip_o | output | 1 | One-cycle pulse on an overwrite or a repeat |

## Verification
Inputs are driven just after a rising system-clock edge, and the block first sees them at the next rising edge. After a transmit sync is driven high, the first edge detects it and loads the shifter. The MSB and the raised enable are therefore sampled at the falling clock edge after that load. The same holds for every bit after a bit-clock rise: one detecting edge, then a sample at the falling edge. The slip pulse is registered and appears in the cycle after the edge that completes or loads a word. A negative-edge monitor counts slip pulses, and each scenario compares the change in that count. The coincident-write case sets the transmit sync one system clock after the last receive bit-clock fall, so that the latch write and the load land on the same edge.

// File: rtl/thru_pkg.sv
package thru_pkg;
  typedef enum logic {
    TX_CODED = 1'b0,
    TX_THRU  = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/edge_pulse.sv
module edge_pulse #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = lvl_i & ~lvl_q;
    end else begin : g_fall
      assign edge_o = ~lvl_i & lvl_q;
    end
  endgenerate
endmodule

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bfall_i,
  input  logic         sync_i,
  input  logic         data_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sync_q;
  logic             start;

  assign start = bfall_i & sync_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sync_q <= 1'b0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (bfall_i) begin
        sync_q <= sync_i;
        if (start) begin
          sh_q  <= {{(W-1){1'b0}}, data_i};
          cnt_q <= CNT_W'(1);
        end else if (cnt_q != '0) begin
          sh_q <= {sh_q[W-2:0], data_i};
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            word_o <= {sh_q[W-2:0], data_i};
            vld_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  // completion needs a fresh falling edge, so never two cycles in a row
  p_word_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/word_latch.sv
module word_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         slip_o
);
  logic [W-1:0] word_q;
  logic         fresh_q;
  logic         seen_q;
  logic         ovw;
  logic         rep;

  // a write in the same cycle bypasses to the reader
  assign rdata_o = wr_i ? wdata_i : word_q;
  assign ovw     = wr_i & fresh_q;
  assign rep     = rd_i & ~wr_i & ~fresh_q & seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      fresh_q <= 1'b0;
      seen_q  <= 1'b0;
      slip_o  <= 1'b0;
    end else begin
      slip_o <= ovw | rep;
      if (wr_i) begin
        word_q <= wdata_i;
        seen_q <= 1'b1;
      end
      if (rd_i)      fresh_q <= 1'b0;
      else if (wr_i) fresh_q <= 1'b1;
    end
  end

  p_overwrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && fresh_q) |=> slip_o);
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !rd_i) |=> !slip_o);
  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !fresh_q);
endmodule

// File: rtl/tx_ser.sv
module tx_ser
  import thru_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          brise_i,
  input  logic          thru_i,
  input  logic [W-1:0]  word_i,
  input  logic [CW-1:0] code_i,
  output logic          data_o,
  output logic          oe_o
);
  localparam int CNT_W = $clog2(W + 1);

  tx_mode_e         mode;
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             oe_q;

  assign mode   = tx_mode_e'(thru_i);
  assign oe_o   = oe_q;
  assign data_o = oe_q & sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      len_q <= '0;
      oe_q  <= 1'b0;
    end else if (load_i) begin
      sh_q  <= (mode == TX_THRU) ? word_i : {code_i, {(W-CW){1'b0}}};
      len_q <= (mode == TX_THRU) ? CNT_W'(W) : CNT_W'(CW);
      cnt_q <= '0;
      oe_q  <= 1'b1;
    end else if (oe_q && brise_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == len_q - CNT_W'(1)) begin
        oe_q <= 1'b0;
        sh_q <= '0;
      end else begin
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
    end
  end

  p_load_drives_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> oe_o);
  p_hold_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !brise_i && !load_i) |=> (oe_o && $stable(data_o)));
  p_end_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> $past(brise_i));
  p_idle_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_o && !load_i) |=> (!data_o || oe_o));
endmodule

// File: rtl/xrate_thru.sv
module xrate_thru #(
  parameter int WORD_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bclk_i,
  input  logic              rx_sync_i,
  input  logic              rx_data_i,
  input  logic              tx_bclk_i,
  input  logic              tx_sync_i,
  input  logic              thru_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tx_data_o,
  output logic              tx_oe_o,
  output logic              slip_o
);
  logic              rx_fall;
  logic              tx_rise;
  logic              tx_load;
  logic              rd;
  logic              wr;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] held;

  edge_pulse #(.RISE(1'b0)) i_rx_bclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rx_bclk_i), .edge_o(rx_fall));
  edge_pulse #(.RISE(1'b1)) i_tx_bclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tx_bclk_i), .edge_o(tx_rise));
  edge_pulse #(.RISE(1'b1)) i_tx_sync_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tx_sync_i), .edge_o(tx_load));

  rx_deser #(.W(WORD_W)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .bfall_i(rx_fall), .sync_i(rx_sync_i),
    .data_i(rx_data_i), .word_o(rx_word), .vld_o(wr));

  // only a through-mode load consumes the latch
  assign rd = tx_load & thru_i;

  word_latch #(.W(WORD_W)) i_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(rx_word),
    .rd_i(rd), .rdata_o(held), .slip_o(slip_o));

  tx_ser #(.W(WORD_W), .CW(CODE_W)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tx_load), .brise_i(tx_rise),
    .thru_i(thru_i), .word_i(held), .code_i(code_i),
    .data_o(tx_data_o), .oe_o(tx_oe_o));

  p_bypass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && wr) |=> (tx_oe_o && tx_data_o == $past(rx_word[WORD_W-1])));
endmodule

// File: tb/test_xrate_thru.sv
module test_xrate_thru;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bclk = 1'b0, rx_sync = 1'b0, rx_data = 1'b0;
  logic tx_bclk = 1'b0, tx_sync = 1'b0, thru = 1'b1;
  logic [3:0] code = 4'h0;
  logic tx_data, tx_oe, slip;

  int checks = 0;
  int errors = 0;
  int slips = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  xrate_thru i_xrate_thru (
    .clk_i(clk), .rst_ni(rst_n), .rx_bclk_i(rx_bclk), .rx_sync_i(rx_sync),
    .rx_data_i(rx_data), .tx_bclk_i(tx_bclk), .tx_sync_i(tx_sync),
    .thru_i(thru), .code_i(code), .tx_data_o(tx_data), .tx_oe_o(tx_oe),
    .slip_o(slip));

  always @(negedge clk) if (rst_n && slip) slips++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns right after the 8th falling bit-clock edge is driven
  task automatic send_word(input logic [7:0] w, input int half);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      rx_bclk <= 1'b1;
      rx_sync <= (i == 0);
      rx_data <= w[7-i];
      repeat (half) @(posedge clk);
      rx_bclk <= 1'b0;
      if (i < 7) repeat (half - 1) @(posedge clk);
    end
  endtask

  task automatic tx_frame(input logic [7:0] exp, input int nb, input logic mode,
                          input logic flip, input int half, input string req);
    logic [7:0] got = 8'h00;
    bit oe_ok = 1'b1;
    @(posedge clk);
    tx_sync <= 1'b1;
    thru    <= mode;
    @(posedge clk);
    @(negedge clk);
    if (!tx_oe) oe_ok = 1'b0;
    got[7] = tx_data;
    if (flip) thru <= ~mode;
    for (int k = 1; k <= nb; k++) begin
      repeat (half) @(posedge clk);
      tx_bclk <= 1'b1;
      tx_sync <= 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (k < nb) begin
        if (!tx_oe) oe_ok = 1'b0;
        got[7-k] = tx_data;
      end else begin
        check(!tx_oe && !tx_data, {req, " line released after last bit"}, tx_oe, 0);
      end
      repeat (half) @(posedge clk);
      tx_bclk <= 1'b0;
    end
    check(oe_ok, {req, " enable held during word"}, oe_ok, 1);
    check(got == exp, {req, " word"}, got, exp);
    thru <= 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!tx_oe && !tx_data && !slip, "R1 reset outputs", {tx_oe, tx_data, slip}, 0);
  endtask

  task automatic t_basic();
    int s0 = slips;
    send_word(8'hA5, 3);
    repeat (6) @(posedge clk);
    tx_frame(8'hA5, 8, 1'b1, 1'b0, 4, "R2 R3 through");
    check(slips == s0, "R3 no slip", slips - s0, 0);
  endtask

  task automatic t_repeat();
    int s0 = slips;
    tx_frame(8'hA5, 8, 1'b1, 1'b0, 2, "R8 repeat");
    check(slips == s0 + 1, "R8 repeat slip", slips - s0, 1);
  endtask

  task automatic t_overwrite();
    int s0 = slips;
    send_word(8'h3C, 2);
    repeat (4) @(posedge clk);
    send_word(8'hC3, 5);
    repeat (4) @(posedge clk);
    check(slips == s0 + 1, "R7 overwrite slip", slips - s0, 1);
    tx_frame(8'hC3, 8, 1'b1, 1'b0, 3, "R7 newer word kept");
  endtask

  task automatic t_coded();
    int s0;
    code = 4'b1011;
    tx_frame(8'hB0, 4, 1'b0, 1'b1, 3, "R4 R5 coded");
    s0 = slips;
    send_word(8'h5A, 3);
    repeat (4) @(posedge clk);
    code = 4'b0110;
    tx_frame(8'h60, 4, 1'b0, 1'b0, 2, "R9 coded leaves latch");
    tx_frame(8'h5A, 8, 1'b1, 1'b1, 2, "R9 R5 through after coded");
    check(slips == s0, "R9 no slip", slips - s0, 0);
  endtask

  task automatic t_phase();
    int s0 = slips;
    fork
      send_word(8'h96, 6);
      begin
        repeat (40) @(posedge clk);
        tx_frame(8'h5A, 8, 1'b1, 1'b0, 2, "R6 sync before latch");
      end
    join
    repeat (4) @(posedge clk);
    tx_frame(8'h96, 8, 1'b1, 1'b0, 3, "R6 word in next frame");
    check(slips == s0 + 1, "R6 one repeat slip", slips - s0, 1);
  endtask

  task automatic t_coincident();
    int s0 = slips;
    send_word(8'h0F, 3);
    tx_frame(8'h0F, 8, 1'b1, 1'b0, 3, "R10 coincident write and load");
    check(slips == s0, "R10 no slip", slips - s0, 0);
    @(negedge clk);
    check(!tx_oe && !tx_data, "R11 idle line low", tx_data, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    t_reset();
    t_basic();
    t_repeat();
    t_overwrite();
    t_coded();
    t_phase();
    t_coincident();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule